// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregator

This block merges many interrupt sources into a single registered IRQ output. The switch sources come from a buffer manager, a switch engine and three port MACs. They pass through three tiers: per-group pending and mask registers, then a switch summary pending/mask pair, then one bit of a top-level status word. The time-stamp sources pass through two tiers. They sit in one combined status-and-enable register, and that register feeds a second bit of the same status word. The top-level status is gated by a per-bit enable word and then by one global output enable.

Software reaches every register through a plain strobe port. It writes with `wrEn`, `addr` and `wrData`, and it reads `rdData` combinationally from `addr`. Pending bits are sticky and are cleared by writing 1. Summary and top-level status bits are not stored. They follow the enabled bits of the tier below them.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every register reads zero and `irqOut` is 0.
- R2: A low-level pending bit is set by a 1-cycle pulse on its event input and stays set until 1 is written to it (address 5 for the buffer manager, 7 for the switch engine). If an event arrives in the same cycle as the clear, the bit stays set.
- R3: Mask registers (address 6 for the buffer manager, 8 for the switch engine) enable a pending bit when the mask bit is 1. The summary pending register (address 3, read-only) has bit 0 for the buffer manager, bit 1 for the switch engine and bit 2 for the MACs. Each summary bit is the OR of its group's pending bits ANDed with their mask bits.
- R4: The top status word (address 0, read-only) carries the switch event at bit 28. That bit is the OR of the summary bits ANDed with the summary mask (address 4, bits 2:0). The time-stamp event is at bit 29 and is the OR of the time-stamp status bits ANDed with their enables.
- R5: The time-stamp register (address 15) holds status bits 8:0, one per event input index, cleared by writing 1. It holds plain read/write enable bits 24:16, where enable bit 16+i belongs to status bit i.
- R6: `irqOut` is registered. One clock after a change, it equals global enable (address 2, bit 8) AND the OR of (top status bits 29/28 ANDed with top enable bits 29/28 at address 1).
- R7: The MAC pending registers (addresses 9 to 11) and MAC mask registers (addresses 12 to 14) always read zero, and writes to them have no effect.
- R8: Writes to the top status word and the summary pending register have no effect.
- R9: Bits outside the defined fields read zero (top enable keeps only bits 29 and 28, configuration keeps only bit 8).
- R10: `irqOut` falls one clock after the last enabled pending bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| bmEvent | input | BM_SRC | Buffer manager event pulses |
| seEvent | input | SE_SRC | Switch engine event pulses |
| tsEvent | input | TS_SRC | Time-stamp event pulses (captures, GPIO captures, timer) |
| irqOut | output | 1 | Registered interrupt request |

## Verification
A single buffer-manager source is walked up the tree one enable at a time. The bench reads the summary, top status and `irqOut` after each step, so a fault in any one gate shows as an early or late rise. The same pattern is repeated for a switch-engine source and for the time-stamp timer source. These runs tell apart the summary bit positions and the two top-level bits. Event-against-clear collisions and clears of the last enabled bit check stickiness and the one-clock deassertion. Writes to read-only, MAC and reserved bit locations must leave the read-back and `irqOut` unchanged.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_TOP_STAT = 4'd0;
  localparam logic [ADDR_W-1:0] A_TOP_EN   = 4'd1;
  localparam logic [ADDR_W-1:0] A_CFG      = 4'd2;
  localparam logic [ADDR_W-1:0] A_SUM_PEND = 4'd3;
  localparam logic [ADDR_W-1:0] A_SUM_MASK = 4'd4;
  localparam logic [ADDR_W-1:0] A_BM_PEND  = 4'd5;
  localparam logic [ADDR_W-1:0] A_BM_MASK  = 4'd6;
  localparam logic [ADDR_W-1:0] A_SE_PEND  = 4'd7;
  localparam logic [ADDR_W-1:0] A_SE_MASK  = 4'd8;
  localparam logic [ADDR_W-1:0] A_TS_REG   = 4'd15;

  localparam int TOP_TS_BIT    = 29;
  localparam int TOP_SW_BIT    = 28;
  localparam int CFG_IRQEN_BIT = 8;
  localparam int TS_EN_OFS     = 16;
  localparam int SUM_GROUPS    = 3;

  typedef struct packed {
    logic topEnWr;
    logic cfgWr;
    logic sumMaskWr;
    logic bmClr;
    logic bmMaskWr;
    logic seClr;
    logic seMaskWr;
    logic tsWr;
  } regStrobe_t;
endpackage

// File: rtl/irq_pend_cell.sv
module irq_pend_cell #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] evt,
  input  logic         clrStb,
  input  logic [N-1:0] clrBits,
  input  logic         maskStb,
  input  logic [N-1:0] maskBits,
  output logic [N-1:0] pend,
  output logic [N-1:0] mask,
  output logic         hit
);
  logic [N-1:0] clrVec;

  assign clrVec = clrStb ? clrBits : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= '0;
      mask <= '0;
    end else begin
      pend <= (pend & ~clrVec) | evt;
      if (maskStb) mask <= maskBits;
    end
  end

  assign hit = |(pend & mask);

  // R2: a set bit survives any cycle without a clear strobe
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !clrStb |=> ((pend & $past(pend)) == $past(pend)));

  // R2: an arriving event always leaves its bit set, even against a clear
  a_r2_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|evt) |=> ((pend & $past(evt)) == $past(evt)));
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        stb
);
  always_comb begin
    stb = '0;
    if (wrEn) begin
      unique case (addr)
        A_TOP_EN:   stb.topEnWr   = 1'b1;
        A_CFG:      stb.cfgWr     = 1'b1;
        A_SUM_MASK: stb.sumMaskWr = 1'b1;
        A_BM_PEND:  stb.bmClr     = 1'b1;
        A_BM_MASK:  stb.bmMaskWr  = 1'b1;
        A_SE_PEND:  stb.seClr     = 1'b1;
        A_SE_MASK:  stb.seMaskWr  = 1'b1;
        A_TS_REG:   stb.tsWr      = 1'b1;
        default:    stb           = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int BM_SRC = 4,
  parameter int SE_SRC = 4,
  parameter int TS_SRC = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BM_SRC-1:0] bmEvent,
  input  logic [SE_SRC-1:0] seEvent,
  input  logic [TS_SRC-1:0] tsEvent,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  logic [BM_SRC-1:0] bmPend, bmMask;
  logic [SE_SRC-1:0] sePend, seMask;
  logic [TS_SRC-1:0] tsStat, tsEn;
  logic bmHit, seHit, tsHit, macHit;
  logic [SUM_GROUPS-1:0] sumPend, sumMask;
  logic [1:0] topEn;  // [1] time-stamp, [0] switch
  logic cfgIrqEn, swInt, tsInt;
  logic [DATA_W-1:0] topStat;

  irq_pend_cell #(.N(BM_SRC)) u_bm (
    .clk(clk), .rstN(rstN), .evt(bmEvent),
    .clrStb(stb.bmClr), .clrBits(wrData[BM_SRC-1:0]),
    .maskStb(stb.bmMaskWr), .maskBits(wrData[BM_SRC-1:0]),
    .pend(bmPend), .mask(bmMask), .hit(bmHit));

  irq_pend_cell #(.N(SE_SRC)) u_se (
    .clk(clk), .rstN(rstN), .evt(seEvent),
    .clrStb(stb.seClr), .clrBits(wrData[SE_SRC-1:0]),
    .maskStb(stb.seMaskWr), .maskBits(wrData[SE_SRC-1:0]),
    .pend(sePend), .mask(seMask), .hit(seHit));

  irq_pend_cell #(.N(TS_SRC)) u_ts (
    .clk(clk), .rstN(rstN), .evt(tsEvent),
    .clrStb(stb.tsWr), .clrBits(wrData[TS_SRC-1:0]),
    .maskStb(stb.tsWr), .maskBits(wrData[TS_EN_OFS +: TS_SRC]),
    .pend(tsStat), .mask(tsEn), .hit(tsHit));

  assign macHit  = 1'b0;  // port MACs carry no active sources
  assign sumPend = {macHit, seHit, bmHit};
  assign swInt   = |(sumPend & sumMask);
  assign tsInt   = tsHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topEn    <= '0;
      cfgIrqEn <= 1'b0;
      sumMask  <= '0;
      irqOut   <= 1'b0;
    end else begin
      if (stb.topEnWr) topEn <= {wrData[TOP_TS_BIT], wrData[TOP_SW_BIT]};
      if (stb.cfgWr) cfgIrqEn <= wrData[CFG_IRQEN_BIT];
      if (stb.sumMaskWr) sumMask <= wrData[SUM_GROUPS-1:0];
      irqOut <= cfgIrqEn & |({tsInt, swInt} & topEn);
    end
  end

  always_comb begin
    topStat = '0;
    topStat[TOP_TS_BIT] = tsInt;
    topStat[TOP_SW_BIT] = swInt;
  end

  always_comb begin
    rdData = '0;
    case (addr)
      A_TOP_STAT: rdData = topStat;
      A_TOP_EN: begin
        rdData[TOP_TS_BIT] = topEn[1];
        rdData[TOP_SW_BIT] = topEn[0];
      end
      A_CFG:      rdData[CFG_IRQEN_BIT] = cfgIrqEn;
      A_SUM_PEND: rdData = DATA_W'(sumPend);
      A_SUM_MASK: rdData = DATA_W'(sumMask);
      A_BM_PEND:  rdData = DATA_W'(bmPend);
      A_BM_MASK:  rdData = DATA_W'(bmMask);
      A_SE_PEND:  rdData = DATA_W'(sePend);
      A_SE_MASK:  rdData = DATA_W'(seMask);
      A_TS_REG: begin
        rdData[TS_SRC-1:0] = tsStat;
        rdData[TS_EN_OFS +: TS_SRC] = tsEn;
      end
      default:    rdData = '0;  // MAC pending/mask words read zero
    endcase
  end

  // R6: global enable low keeps the output low on the next cycle
  a_r6_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    !cfgIrqEn |=> !irqOut);

  // R6: enabled top-level cause with global enable raises the output next cycle
  a_r6_follow: assert property (@(posedge clk) disable iff (!rstN)
    (cfgIrqEn && ((tsInt && topEn[1]) || (swInt && topEn[0]))) |=> irqOut);

  // R10: no enabled cause left means the output falls one clock later
  a_r10_drop: assert property (@(posedge clk) disable iff (!rstN)
    (!(tsInt && topEn[1]) && !(swInt && topEn[0])) |=> !irqOut);

  // R3: a summary bit can only be seen when its group has an enabled pending bit
  a_r3_summary_source: assert property (@(posedge clk) disable iff (!rstN)
    swInt |-> ((bmHit && sumMask[0]) || (seHit && sumMask[1])));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int BM_SRC = 4,
  parameter int SE_SRC = 4,
  parameter int TS_SRC = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [BM_SRC-1:0] bmEvent,
  input  logic [SE_SRC-1:0] seEvent,
  input  logic [TS_SRC-1:0] tsEvent,
  output logic              irqOut
);
  regStrobe_t stb;

  irq_agg_ctrl u_ctrl (
    .wrEn(wrEn), .addr(addr), .stb(stb));

  irq_agg_datapath #(.BM_SRC(BM_SRC), .SE_SRC(SE_SRC), .TS_SRC(TS_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .wrData(wrData),
    .bmEvent(bmEvent), .seEvent(seEvent), .tsEvent(tsEvent),
    .rdData(rdData), .irqOut(irqOut));
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0] bmEvent = '0;
  logic [3:0] seEvent = '0;
  logic [8:0] tsEvent = '0;
  logic irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t expQ[$];

  always #5 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .bmEvent(bmEvent), .seEvent(seEvent),
    .tsEvent(tsEvent), .irqOut(irqOut));

  // monitor: compare one cycle after the driver queued an expectation
  always @(posedge clk) begin
    #2;
    while (expQ.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = expQ.pop_front();
      act = it.isIrq ? {31'd0, irqOut} : rdData;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic readExp(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = a;
    expQ.push_back('{1'b0, e, tag});
  endtask

  task automatic irqNow(input bit e, input string tag);
    expQ.push_back('{1'b1, {31'd0, e}, tag});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 16; a++) readExp(4'(a), 32'h0, "R1 reset read");
    irqNow(1'b0, "R1 reset irq");

    // R2 event sets sticky pending bit
    @(negedge clk); bmEvent = 4'b0100;
    @(negedge clk); bmEvent = '0;
    idle(2);
    readExp(4'd5, 32'h4, "R2 bm pending sticky");
    // R3 unmasked source gives no summary
    readExp(4'd3, 32'h0, "R3 summary masked");
    writeReg(4'd6, 32'h4);
    readExp(4'd3, 32'h1, "R3 summary bit0 bm");
    readExp(4'd0, 32'h0, "R4 top blocked by summary mask");
    writeReg(4'd4, 32'h7);
    readExp(4'd0, 32'h1000_0000, "R4 top bit28 switch");
    // R6 gating chain
    idle(2); irqNow(1'b0, "R6 top enable off");
    writeReg(4'd1, 32'h1000_0000);
    idle(2); irqNow(1'b0, "R6 global enable off");
    writeReg(4'd2, 32'h0000_0100);
    irqNow(1'b1, "R6 irq one clock after enable");
    // R8 read-only writes ignored
    writeReg(4'd0, 32'h0);
    writeReg(4'd3, 32'h0);
    readExp(4'd0, 32'h1000_0000, "R8 top stat unchanged");
    readExp(4'd3, 32'h1, "R8 summary unchanged");
    irqNow(1'b1, "R8 irq unchanged");
    // R10 clear last enabled bit
    writeReg(4'd5, 32'h4);
    irqNow(1'b0, "R10 irq falls one clock after clear");
    readExp(4'd5, 32'h0, "R2 w1c cleared");

    // R2 event wins against simultaneous clear
    @(negedge clk); bmEvent = 4'b0001;
    @(negedge clk); bmEvent = '0;
    @(negedge clk); wrEn = 1'b1; addr = 4'd5; wrData = 32'h1; bmEvent = 4'b0001;
    @(negedge clk); wrEn = 1'b0; wrData = '0; bmEvent = '0;
    readExp(4'd5, 32'h1, "R2 event wins over clear");
    readExp(4'd3, 32'h0, "R3 bit0 masked off");
    writeReg(4'd5, 32'h1);

    // R3 switch engine path, summary bit1
    writeReg(4'd8, 32'h2);
    @(negedge clk); seEvent = 4'b0010;
    @(negedge clk); seEvent = '0;
    readExp(4'd7, 32'h2, "R2 se pending");
    readExp(4'd3, 32'h2, "R3 summary bit1 se");
    irqNow(1'b1, "R6 irq from se");
    writeReg(4'd4, 32'h1);
    readExp(4'd0, 32'h0, "R4 se blocked by summary mask");
    idle(1); irqNow(1'b0, "R10 irq falls on summary mask");
    writeReg(4'd7, 32'h2);

    // R5 time-stamp path, timer source index 8
    @(negedge clk); tsEvent = 9'h100;
    @(negedge clk); tsEvent = '0;
    readExp(4'd15, 32'h0000_0100, "R5 ts status bit8");
    readExp(4'd0, 32'h0, "R4 ts disabled");
    writeReg(4'd15, 32'h0100_0000);
    readExp(4'd15, 32'h0100_0100, "R5 enable rw, status kept");
    readExp(4'd0, 32'h2000_0000, "R4 top bit29 ts");
    idle(2); irqNow(1'b0, "R6 ts top enable off");
    writeReg(4'd1, 32'hFFFF_FFFF);
    readExp(4'd1, 32'h3000_0000, "R9 top enable field");
    irqNow(1'b1, "R6 irq from ts");
    writeReg(4'd15, 32'h0100_0100);
    irqNow(1'b0, "R10 irq falls after ts clear");
    readExp(4'd15, 32'h0100_0000, "R5 ts w1c");

    // R7 MAC words, R9 configuration field
    for (int a = 9; a < 15; a++) writeReg(4'(a), 32'hFFFF_FFFF);
    for (int a = 9; a < 15; a++) readExp(4'(a), 32'h0, "R7 mac reads zero");
    writeReg(4'd2, 32'hFFFF_FFFF);
    readExp(4'd2, 32'h0000_0100, "R9 cfg field");
    readExp(4'd3, 32'h0, "R7 mac summary bit2 idle");
    idle(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule